// File: doc/BRIEF.md
# UART Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It watches the RX line through a synchronizer. On each oversample tick it samples the line. From those samples it builds a character of eight data bits, sent least significant bit first, with an optional parity bit and one or two stop bits. Every finished character goes into a data register. Three error indications travel with it: noise, framing and parity.

The noise indication is set when the samples taken near the middle of any bit disagree. It is sticky. Software clears it by reading the status word and then the data word, in that order. The framing and parity indications are replaced by the values of each new character. A data-available flag goes up whenever a character lands in the data register, and a read of the data word takes it down.

Baud-rate generation, the transmitter and interrupt handling live elsewhere. The parent supplies the oversample tick, the configuration levels and single-cycle read strobes.

Top module: `uart_rx_chk`

## Requirements
- R1: Each bit spans OSR ticks, counted from the tick on which the start edge is seen as offset 0. The bit value is the majority of the samples at offsets OSR/2-1, OSR/2 and OSR/2+1. A one-tick glitch at any other offset has no effect on the received character or its flags.
- R2: If the three voting samples of any bit in an accepted frame disagree, the frame's noise flag is set. The character is still delivered with its majority-voted data.
- R3: A start edge is accepted only if the voted start-bit value is low. Otherwise the receiver returns to idle, and no character or flag change results.
- R4: The data word (status-independent output `rxdata_o`) holds the eight data bits received LSB first, loaded once per accepted frame.
- R5: When parity is enabled, the parity bit follows the data. The parity error flag is set when the received parity bit differs from XOR(data) for even parity (`cfg_par_odd`=0), or from XOR(data) inverted for odd parity (`cfg_par_odd`=1).
- R6: When parity is disabled, no parity bit is expected and the parity error flag of the delivered character is 0.
- R7: The framing error flag is set if the first stop bit is voted low. When two stop bits are configured (`cfg_two_stop`=1), it is also set if the second stop bit is voted low.
- R8: `status_o` is {avail, noise, framing error, parity error} on bits 3..0. Avail is set when a character is transferred and cleared by a `rd_rxdata` strobe.
- R9: The noise flag rises only together with a character transfer. Once set, it is not cleared by a later clean character.
- R10: The noise flag is cleared only by a `rd_rxdata` strobe that comes after a `rd_status` strobe, with no character transfer in between. A data read alone, or a data read followed by a status read, leaves it set.
- R11: The framing and parity flags take the values of each transferred character and hold until the next one.
- R12: After reset, status_o and rxdata_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample tick, OSR per bit time |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd_status | input | 1 | Status read strobe |
| rd_rxdata | input | 1 | Data read strobe |
| status_o | output | 4 | {avail, noise, framing error, parity error} |
| rxdata_o | output | DATA_W | Received data word |

## Verification
The bench uses the default parameters: 16 samples per bit, an 8-bit word and a two-stage synchronizer, with the tick held high so that each bit lasts sixteen clocks. At that size it is practical to send all 256 data values. Each value also selects a parity mode, a stop-bit count, injected parity and stop errors, and a one-clock glitch at a computed offset. A separate sweep moves a glitch through all sixteen offsets of one bit, which reaches every voting position and every position outside the vote. Directed sequences cover false starts and the orderings of the read strobes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rx_state_e;

   typedef struct packed {
      logic noise;
      logic ferr;
      logic perr;
   } rx_flags_t;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic split3(input logic a, input logic b, input logic c);
      return !((a == b) && (b == c));
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '1;
            end else begin
               for (int i = STAGES-1; i > 0; i--) begin
                  pipe[i] <= pipe[i-1];
               end
               pipe[0] <= d_i;
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler import uart_rx_pkg::*; #(
   parameter int OSR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rx_i,
   input  logic run_i,
   input  logic launch_i,
   output logic vote_stb_o,
   output logic vote_val_o,
   output logic vote_noisy_o,
   output logic bit_end_o
);

   localparam int CW  = $clog2(OSR);
   localparam int MID = OSR / 2;
   localparam logic [CW-1:0] POS_LO  = CW'(MID - 1);
   localparam logic [CW-1:0] POS_MID = CW'(MID);
   localparam logic [CW-1:0] POS_HI  = CW'(MID + 1);
   localparam logic [CW-1:0] POS_END = CW'(OSR - 1);
   localparam logic [CW-1:0] POS_ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          smp_lo_q;
   logic          smp_mid_q;
   logic          adv;

   assign adv = run_i && tick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         smp_lo_q  <= 1'b1;
         smp_mid_q <= 1'b1;
      end else begin
         if (launch_i) begin
            cnt_q <= POS_ONE;
         end else if (!run_i) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            cnt_q <= (cnt_q == POS_END) ? '0 : cnt_q + POS_ONE;
         end
         if (adv && cnt_q == POS_LO) begin
            smp_lo_q <= rx_i;
         end
         if (adv && cnt_q == POS_MID) begin
            smp_mid_q <= rx_i;
         end
      end
   end

   assign vote_stb_o   = adv && (cnt_q == POS_HI);
   assign vote_val_o   = vote3(smp_lo_q, smp_mid_q, rx_i);
   assign vote_noisy_o = split3(smp_lo_q, smp_mid_q, rx_i);
   assign bit_end_o    = adv && (cnt_q == POS_END);

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer import uart_rx_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              two_stop_i,
   input  logic              vote_stb_i,
   input  logic              vote_val_i,
   input  logic              vote_noisy_i,
   input  logic              bit_end_i,
   output logic              run_o,
   output logic              launch_o,
   output logic              char_stb_o,
   output logic [DATA_W-1:0] char_data_o,
   output rx_flags_t         char_flags_o
);

   localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

   rx_state_e         st_q;
   logic [IW-1:0]     idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              pbit_q;
   logic              stop1_q;
   logic              noise_acc_q;

   logic exp_par;
   logic noise_fin;
   logic perr_fin;

   assign run_o     = (st_q != ST_IDLE);
   assign launch_o  = (st_q == ST_IDLE) && tick_i && !rx_i;
   assign exp_par   = (^shreg_q) ^ par_odd_i;
   assign noise_fin = noise_acc_q | vote_noisy_i;
   assign perr_fin  = par_en_i && (pbit_q != exp_par);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         idx_q        <= '0;
         shreg_q      <= '0;
         pbit_q       <= 1'b0;
         stop1_q      <= 1'b1;
         noise_acc_q  <= 1'b0;
         char_stb_o   <= 1'b0;
         char_data_o  <= '0;
         char_flags_o <= '0;
      end else begin
         char_stb_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (launch_o) begin
                  st_q        <= ST_START;
                  noise_acc_q <= 1'b0;
               end
            end
            ST_START: begin
               if (vote_stb_i) begin
                  if (vote_val_i) begin
                     st_q <= ST_IDLE;
                  end else begin
                     noise_acc_q <= vote_noisy_i;
                  end
               end
               if (bit_end_i) begin
                  st_q  <= ST_DATA;
                  idx_q <= '0;
               end
            end
            ST_DATA: begin
               if (vote_stb_i) begin
                  shreg_q     <= {vote_val_i, shreg_q[DATA_W-1:1]};
                  noise_acc_q <= noise_fin;
               end
               if (bit_end_i) begin
                  if (idx_q == IDX_LAST) begin
                     st_q <= par_en_i ? ST_PAR : ST_STOP1;
                  end else begin
                     idx_q <= idx_q + IW'(1);
                  end
               end
            end
            ST_PAR: begin
               if (vote_stb_i) begin
                  pbit_q      <= vote_val_i;
                  noise_acc_q <= noise_fin;
               end
               if (bit_end_i) begin
                  st_q <= ST_STOP1;
               end
            end
            ST_STOP1: begin
               if (vote_stb_i) begin
                  if (two_stop_i) begin
                     stop1_q     <= vote_val_i;
                     noise_acc_q <= noise_fin;
                  end else begin
                     char_stb_o   <= 1'b1;
                     char_data_o  <= shreg_q;
                     char_flags_o <= '{noise: noise_fin, ferr: !vote_val_i, perr: perr_fin};
                     st_q         <= ST_IDLE;
                  end
               end
               if (bit_end_i) begin
                  st_q <= ST_STOP2;
               end
            end
            ST_STOP2: begin
               if (vote_stb_i) begin
                  char_stb_o   <= 1'b1;
                  char_data_o  <= shreg_q;
                  char_flags_o <= '{noise: noise_fin, ferr: !stop1_q || !vote_val_i,
                                    perr: perr_fin};
                  st_q         <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs import uart_rx_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_stb_i,
   input  logic [DATA_W-1:0] char_data_i,
   input  rx_flags_t         char_flags_i,
   input  logic              rd_stat_i,
   input  logic              rd_data_i,
   output logic              avail_o,
   output logic              noise_o,
   output logic              ferr_o,
   output logic              perr_o,
   output logic [DATA_W-1:0] data_o
);

   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         avail_o <= 1'b0;
         noise_o <= 1'b0;
         ferr_o  <= 1'b0;
         perr_o  <= 1'b0;
         arm_q   <= 1'b0;
      end else if (char_stb_i) begin
         data_o  <= char_data_i;
         avail_o <= 1'b1;
         noise_o <= noise_o | char_flags_i.noise;
         ferr_o  <= char_flags_i.ferr;
         perr_o  <= char_flags_i.perr;
         arm_q   <= 1'b0;
      end else if (rd_data_i) begin
         avail_o <= 1'b0;
         arm_q   <= 1'b0;
         if (arm_q) begin
            noise_o <= 1'b0;
         end
      end else if (rd_stat_i) begin
         arm_q <= 1'b1;
      end
   end

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk import uart_rx_pkg::*; #(
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_line,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              rd_status,
   input  logic              rd_rxdata,
   output logic [3:0]        status_o,
   output logic [DATA_W-1:0] rxdata_o
);

   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 8");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              rx_s;
   logic              run;
   logic              launch;
   logic              vote_stb;
   logic              vote_val;
   logic              vote_noisy;
   logic              bit_end;
   logic              char_stb;
   logic [DATA_W-1:0] char_data;
   rx_flags_t         char_flags;
   logic              avail;
   logic              noise;
   logic              ferr;
   logic              perr;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_line),
      .q_o   (rx_s)
   );

   uart_rx_sampler #(.OSR(OSR)) u_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (os_tick),
      .rx_i         (rx_s),
      .run_i        (run),
      .launch_i     (launch),
      .vote_stb_o   (vote_stb),
      .vote_val_o   (vote_val),
      .vote_noisy_o (vote_noisy),
      .bit_end_o    (bit_end)
   );

   uart_rx_framer #(.DATA_W(DATA_W)) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (os_tick),
      .rx_i         (rx_s),
      .par_en_i     (cfg_par_en),
      .par_odd_i    (cfg_par_odd),
      .two_stop_i   (cfg_two_stop),
      .vote_stb_i   (vote_stb),
      .vote_val_i   (vote_val),
      .vote_noisy_i (vote_noisy),
      .bit_end_i    (bit_end),
      .run_o        (run),
      .launch_o     (launch),
      .char_stb_o   (char_stb),
      .char_data_o  (char_data),
      .char_flags_o (char_flags)
   );

   uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .char_stb_i   (char_stb),
      .char_data_i  (char_data),
      .char_flags_i (char_flags),
      .rd_stat_i    (rd_status),
      .rd_data_i    (rd_rxdata),
      .avail_o      (avail),
      .noise_o      (noise),
      .ferr_o       (ferr),
      .perr_o       (perr),
      .data_o       (rxdata_o)
   );

   assign status_o = {avail, noise, ferr, perr};

endmodule

// File: rtl/uart_rx_chk_sva.sv
module uart_rx_chk_sva #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_stb,
   input logic              char_perr,
   input logic              cfg_par_en,
   input logic              rd_data,
   input logic [3:0]        status,
   input logic [DATA_W-1:0] rxdata
);

   AST_AVAIL_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[3]) |-> $past(char_stb)); // R8
   AST_AVAIL_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[3]) |-> $past(rd_data)); // R8
   AST_NOISE_WITH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[2]) |-> (status[3] && $past(char_stb))); // R9
   AST_NOISE_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[2]) |-> $past(rd_data)); // R10
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(char_stb) |-> ($stable(status[1:0]) && $stable(rxdata))); // R11
   AST_NO_PERR_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && !$past(cfg_par_en)) |-> !char_perr); // R6
   AST_SINGLE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
      char_stb |=> !char_stb); // R4

endmodule

bind uart_rx_chk uart_rx_chk_sva #(.DATA_W(DATA_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .char_stb   (char_stb),
   .char_perr  (char_flags.perr),
   .cfg_par_en (cfg_par_en),
   .rd_data    (rd_rxdata),
   .status     (status_o),
   .rxdata     (rxdata_o)
);

// File: tb/uart_rx_chk_tb.sv
module uart_rx_chk_tb;

   localparam int OSR = 16;
   localparam int GAP = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx_line = 1'b1;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       rd_status = 1'b0;
   logic       rd_rxdata = 1'b0;
   logic [3:0] status_o;
   logic [7:0] rxdata_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uart_rx_chk u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .os_tick      (os_tick),
      .rx_line      (rx_line),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_odd  (cfg_par_odd),
      .cfg_two_stop (cfg_two_stop),
      .rd_status    (rd_status),
      .rd_rxdata    (rd_rxdata),
      .status_o     (status_o),
      .rxdata_o     (rxdata_o)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic pulse_stat();
      @(negedge clk) rd_status = 1'b1;
      @(negedge clk) rd_status = 1'b0;
   endtask

   task automatic pulse_data();
      @(negedge clk) rd_rxdata = 1'b1;
      @(negedge clk) rd_rxdata = 1'b0;
   endtask

   task automatic idle_line(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) rx_line = 1'b1;
      end
   endtask

   // gbit: bit position in the frame (0 = start) to glitch, -1 for none
   task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic s1,
                             input logic s2, input int gbit, input int goff);
      logic [11:0] bits;
      int nb;
      bits[0] = 1'b0;
      for (int i = 0; i < 8; i++) bits[1+i] = d[i];
      nb = 9;
      if (cfg_par_en) begin
         bits[nb] = (^d) ^ cfg_par_odd ^ flip_par;
         nb++;
      end
      bits[nb] = s1;
      nb++;
      if (cfg_two_stop) begin
         bits[nb] = s2;
         nb++;
      end
      for (int b = 0; b < nb; b++) begin
         for (int o = 0; o < OSR; o++) begin
            @(negedge clk) rx_line = bits[b] ^ ((b == gbit) && (o == goff));
         end
      end
      idle_line(GAP);
   endtask

   // send, check flags and data, then read status and data and check the clear
   task automatic frame_check(input logic [7:0] d, input logic flip_par, input logic s1,
                              input logic s2, input int gbit, input int goff);
      int e_noise;
      int e_ferr;
      int e_perr;
      send_frame(d, flip_par, s1, s2, gbit, goff);
      e_noise = (gbit >= 0 && goff >= OSR/2-1 && goff <= OSR/2+1) ? 1 : 0;
      e_ferr  = (!s1 || (cfg_two_stop && !s2)) ? 1 : 0;
      e_perr  = (cfg_par_en && flip_par) ? 1 : 0;
      chk("R8", "avail after frame", int'(status_o[3]), 1);
      chk("R4", "data word", int'(rxdata_o), int'(d));
      chk("R2", "noise flag", int'(status_o[2]), e_noise);
      chk("R7", "framing flag", int'(status_o[1]), e_ferr);
      if (cfg_par_en) chk("R5", "parity flag", int'(status_o[0]), e_perr);
      else            chk("R6", "parity flag unchecked", int'(status_o[0]), 0);
      pulse_stat();
      pulse_data();
      chk("R10", "avail/noise after status+data read", int'(status_o[3:2]), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "status after reset", int'(status_o), 0);
      chk("R12", "data after reset", int'(rxdata_o), 0);

      // R3: short low pulses on an idle line never make a character
      for (int w = 1; w <= 8; w++) begin
         for (int i = 0; i < w; i++) @(negedge clk) rx_line = 1'b0;
         idle_line(GAP);
         chk("R3", "no char after short low", int'(status_o), 0);
         chk("R3", "data untouched after short low", int'(rxdata_o), 0);
      end

      // R1/R2: one-clock glitch on data bit 3 at every offset, 8N1
      for (int off = 0; off < OSR; off++) begin
         frame_check(8'hA5, 1'b0, 1'b1, 1'b1, 4, off);
         if (off < OSR/2-1 || off > OSR/2+1)
            chk("R1", "glitch outside vote ignored", int'(rxdata_o), 8'hA5);
      end

      // R4..R7 sweep over every data value with rotating format and errors
      for (int v = 0; v < 256; v++) begin
         logic [7:0] vv;
         vv = v[7:0];
         cfg_par_en   = vv[0];
         cfg_par_odd  = vv[1];
         cfg_two_stop = vv[2];
         frame_check(vv, vv[4] & vv[3], !(vv[6] & vv[5]), !(vv[7] & !vv[5]),
                     1 + (v % 8), (v * 5) % OSR);
      end

      cfg_par_en = 1'b0;
      cfg_par_odd = 1'b0;
      cfg_two_stop = 1'b0;

      // R9/R10: sticky noise and read ordering
      send_frame(8'h3C, 1'b0, 1'b1, 1'b1, 2, OSR/2);
      chk("R9", "noise with avail", int'(status_o[3:2]), 3);
      pulse_data();
      chk("R10", "data read alone keeps noise", int'(status_o[3:2]), 1);
      send_frame(8'hC3, 1'b0, 1'b1, 1'b1, -1, 0);
      chk("R9", "clean char keeps noise", int'(status_o[3:2]), 3);
      chk("R4", "second char data", int'(rxdata_o), 8'hC3);
      pulse_data();
      pulse_stat();
      chk("R10", "data then status keeps noise", int'(status_o[2]), 1);
      pulse_data();
      chk("R10", "status then data clears noise", int'(status_o[2]), 0);

      // R10: a character between status read and data read cancels the clear
      send_frame(8'h11, 1'b0, 1'b1, 1'b1, 5, OSR/2-1);
      pulse_stat();
      send_frame(8'h22, 1'b0, 1'b1, 1'b1, -1, 0);
      pulse_data();
      chk("R10", "char between reads keeps noise", int'(status_o[2]), 1);
      pulse_stat();
      pulse_data();
      chk("R10", "fresh sequence clears noise", int'(status_o[2]), 0);

      // R11: flags replaced by the next character without any read
      cfg_par_en = 1'b1;
      send_frame(8'h5A, 1'b1, 1'b0, 1'b1, -1, 0);
      chk("R11", "ferr/perr set", int'(status_o[1:0]), 3);
      send_frame(8'h6B, 1'b0, 1'b1, 1'b1, -1, 0);
      chk("R11", "ferr/perr replaced", int'(status_o[1:0]), 0);
      chk("R11", "data replaced", int'(rxdata_o), 8'h6B);
      pulse_data();
      chk("R11", "flags kept after read", int'(status_o[1:0]), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule